// File: doc/BRIEF.md
# Temperature-Indexed Dual Resistor Code Controller

This block drives the digital control codes of two variable resistors. In automatic mode it turns each new temperature sample from an external converter into a band index, one band for every 2 °C between -40 °C and +102 °C. It reads the matching entry from each resistor's lookup memory and loads both returned codes on the same clock edge. In manual mode the lookup stops and each code is taken from a writable register. A shared disable pin puts both outputs in high impedance.

The lookup memories sit outside the block. The block presents one index with a read strobe, and both memories return their byte on the clock after the strobe. The analog arrays, the temperature sensor and the nonvolatile storage of the tables are all outside this block.

Top module: `temp_code_ctrl`

## Requirements
- R1: In automatic mode (`auto_en_i` = 1), a sample taken on a clock edge where `temp_valid_i` = 1 drives `lut_req_o` high for exactly the next cycle. In that cycle `lut_idx_o` = (temp + 40) / 2, using integer division, for any temperature from -40 to +102.
- R2: A temperature below -40 gives index 0, and a temperature above +102 gives index 71. No index above 71 is ever requested.
- R3: The byte that each memory returns on the cycle after the strobe is loaded into `code0_o` and `code1_o` at the same edge, two edges after the sample. While no lookup is completing in automatic mode, both codes hold.
- R4: In manual mode (`auto_en_i` = 0), a write with `man_addr_i` = 8'h82 sets `code0_o`, and a write with 8'h83 sets `code1_o`. The written value shows at the output after the edge that takes the write.
- R5: A manual write to any other address changes neither code.
- R6: In manual mode, temperature samples are ignored: no read strobe is issued and the codes keep their register values.
- R7: While `disable_i` is high, `hiz0_o` and `hiz1_o` are both high in the same cycle. The code values are left unchanged.
- R8: After reset both codes are 8'h00. Both high-impedance enables stay high until the first code is loaded, either by a completed lookup or by a clock edge in manual mode.
- R9: When the block switches from manual to automatic mode, the codes keep their manual values until the next lookup completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | 8 | Signed temperature in whole °C |
| temp_valid_i | input | 1 | New temperature sample |
| auto_en_i | input | 1 | 1 = table-indexed mode, 0 = manual mode |
| lut_req_o | output | 1 | Read strobe to both lookup memories |
| lut_idx_o | output | 7 | Band index to read |
| lut_rdata0_i | input | 8 | Resistor 0 table byte, valid the cycle after the strobe |
| lut_rdata1_i | input | 8 | Resistor 1 table byte, valid the cycle after the strobe |
| man_we_i | input | 1 | Manual register write strobe |
| man_addr_i | input | 8 | Manual register address |
| man_wdata_i | input | 8 | Manual register write data |
| disable_i | input | 1 | Forces both outputs to high impedance |
| code0_o | output | 8 | Resistor 0 control code |
| code1_o | output | 8 | Resistor 1 control code |
| hiz0_o | output | 1 | Resistor 0 high-impedance enable |
| hiz1_o | output | 1 | Resistor 1 high-impedance enable |

## Verification
A wrong index calculation or a wrong clamp shows on `lut_idx_o` one cycle after the sample, before any code has changed. A fault in the load path shows two edges after the sample: one or both codes hold the wrong byte, or the two codes change on different edges. A fault in the mode or address decode shows one edge after a write or a mode change. A fault in the disable logic or the loaded flag shows on the high-impedance enables in the same cycle.

// File: rtl/temp_code_ctrl.sv
module temp_code_ctrl #(
  parameter int TW = 8,
  parameter int CW = 8,
  parameter int AW = 8,
  parameter int TMIN = -40,
  parameter int TMAX = 102,
  parameter int BAND = 2,
  parameter logic [AW-1:0] MAN0_ADDR = 8'h82,
  parameter logic [AW-1:0] MAN1_ADDR = 8'h83,
  localparam int NENT = (TMAX - TMIN) / BAND + 1,
  localparam int IW = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_i,
  input  logic          temp_valid_i,
  input  logic          auto_en_i,
  output logic          lut_req_o,
  output logic [IW-1:0] lut_idx_o,
  input  logic [CW-1:0] lut_rdata0_i,
  input  logic [CW-1:0] lut_rdata1_i,
  input  logic          man_we_i,
  input  logic [AW-1:0] man_addr_i,
  input  logic [CW-1:0] man_wdata_i,
  input  logic          disable_i,
  output logic [CW-1:0] code0_o,
  output logic [CW-1:0] code1_o,
  output logic          hiz0_o,
  output logic          hiz1_o
);

  localparam int XW = TW + 2;
  localparam logic signed [XW-1:0] LO = XW'(TMIN);
  localparam logic signed [XW-1:0] HI = XW'(TMAX);

  logic signed [XW-1:0] t_ext, t_off;
  logic [IW-1:0] idx_d, idx_q;
  logic req_q, pend_q, loaded_q;
  logic [CW-1:0] man0_q, man1_q, code0_q, code1_q;
  logic wr0, wr1;

  assign t_ext = XW'($signed(temp_i));
  assign t_off = t_ext - LO;

  always_comb begin
    if (t_ext < LO)      idx_d = '0;
    else if (t_ext > HI) idx_d = IW'(NENT - 1);
    else                 idx_d = IW'(t_off / BAND);
  end

  assign wr0 = man_we_i && (man_addr_i == MAN0_ADDR);
  assign wr1 = man_we_i && (man_addr_i == MAN1_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= auto_en_i && temp_valid_i;
      pend_q <= auto_en_i && req_q;
      if (auto_en_i && temp_valid_i) idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man0_q <= '0;
      man1_q <= '0;
    end else begin
      if (wr0) man0_q <= man_wdata_i;
      if (wr1) man1_q <= man_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code0_q  <= '0;
      code1_q  <= '0;
      loaded_q <= 1'b0;
    end else if (!auto_en_i) begin
      code0_q  <= wr0 ? man_wdata_i : man0_q;
      code1_q  <= wr1 ? man_wdata_i : man1_q;
      loaded_q <= 1'b1;
    end else if (pend_q) begin
      code0_q  <= lut_rdata0_i;
      code1_q  <= lut_rdata1_i;
      loaded_q <= 1'b1;
    end
  end

  assign lut_req_o = req_q;
  assign lut_idx_o = idx_q;
  assign code0_o   = code0_q;
  assign code1_o   = code1_q;
  assign hiz0_o    = disable_i || !loaded_q;
  assign hiz1_o    = disable_i || !loaded_q;

  assert_req_follows_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en_i && temp_valid_i) |=> lut_req_o);

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lut_req_o |-> (int'(lut_idx_o) < NENT));

  assert_codes_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en_i && !pend_q) |=> ($stable(code0_o) && $stable(code1_o)));

  assert_manual_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en_i && man_we_i && man_addr_i == MAN0_ADDR) |=> (code0_o == $past(man_wdata_i)));

  assert_manual_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_i |=> !lut_req_o);

  assert_disable_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |-> (hiz0_o && hiz1_o));

endmodule

// File: tb/temp_code_ctrl_tb.sv
module temp_code_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] temp_i = '0;
  logic temp_valid_i = 1'b0, auto_en_i = 1'b1;
  logic lut_req_o;
  logic [6:0] lut_idx_o;
  logic [7:0] lut_rdata0_i = '0, lut_rdata1_i = '0;
  logic man_we_i = 1'b0;
  logic [7:0] man_addr_i = '0, man_wdata_i = '0;
  logic disable_i = 1'b0;
  logic [7:0] code0_o, code1_o;
  logic hiz0_o, hiz1_o;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  temp_code_ctrl u_dut (.*);

  function automatic logic [7:0] f0(input int i); return 8'(i * 3 + 1); endfunction
  function automatic logic [7:0] f1(input int i); return 8'(255 - i * 2); endfunction

  always_ff @(posedge clk) if (lut_req_o) begin
    lut_rdata0_i <= f0(int'(lut_idx_o));
    lut_rdata1_i <= f1(int'(lut_idx_o));
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  localparam int NV = 13;
  localparam int TV[NV] = '{-40, -39, -38, -1, 0, 1, 25, 101, 102, 103, -41, -128, 127};
  localparam int EI[NV] = '{0, 0, 1, 19, 20, 20, 32, 70, 71, 71, 0, 0, 71};

  task automatic sample(input int t, input int ei, input string rq);
    logic [7:0] p0, p1;
    @(negedge clk); temp_i = 8'(t); temp_valid_i = 1'b1;
    p0 = code0_o; p1 = code1_o;
    @(negedge clk); temp_valid_i = 1'b0;
    chk(rq, int'(lut_req_o), 1);
    chk(rq, int'(lut_idx_o), ei);
    @(negedge clk);
    chk("R3", int'(lut_req_o), 0);
    chk("R3", int'({code0_o, code1_o}), int'({p0, p1}));
    @(negedge clk);
    chk("R3", int'(code0_o), int'(f0(ei)));
    chk("R3", int'(code1_o), int'(f1(ei)));
  endtask

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); man_we_i = 1'b1; man_addr_i = a; man_wdata_i = d;
    @(negedge clk); man_we_i = 1'b0;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12;
    chk("R8", int'(code0_o), 0);
    chk("R8", int'(code1_o), 0);
    chk("R8", int'(hiz0_o & hiz1_o), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", int'(hiz0_o | hiz1_o), 1);
    for (int i = 0; i < NV; i++)
      sample(TV[i], EI[i], (TV[i] < -40 || TV[i] > 102) ? "R2" : "R1");
    chk("R8", int'(hiz0_o | hiz1_o), 0);
    disable_i = 1'b1; #1;
    chk("R7", int'(hiz0_o & hiz1_o), 1);
    chk("R7", int'(code0_o), int'(f0(71)));
    disable_i = 1'b0; #1;
    chk("R7", int'(hiz0_o | hiz1_o), 0);
    @(negedge clk); auto_en_i = 1'b0;
    mwrite(8'h82, 8'hA5);
    chk("R4", int'(code0_o), 8'hA5);
    mwrite(8'h83, 8'h3C);
    chk("R4", int'(code1_o), 8'h3C);
    chk("R4", int'(code0_o), 8'hA5);
    mwrite(8'h84, 8'h11);
    mwrite(8'h02, 8'h22);
    chk("R5", int'(code0_o), 8'hA5);
    chk("R5", int'(code1_o), 8'h3C);
    @(negedge clk); temp_i = 8'd50; temp_valid_i = 1'b1;
    @(negedge clk); temp_valid_i = 1'b0;
    chk("R6", int'(lut_req_o), 0);
    repeat (2) @(negedge clk);
    chk("R6", int'(code0_o), 8'hA5);
    chk("R6", int'(code1_o), 8'h3C);
    auto_en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", int'(code0_o), 8'hA5);
    chk("R9", int'(code1_o), 8'h3C);
    sample(50, 45, "R9");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule